// File: doc/BRIEF.md
# Channel Sweep Sequencer with FIFO Interrupt

This block decides which analog channel an external converter samples next and collects the results. The host programs a small configuration word (conversion mode, sweep order, pin function and trigger level) and then raises a start request. The sequencer drives a channel select and a one-cycle start pulse to the converter. It waits for the converter's done strobe and pushes the 12-bit result into an 8-entry result FIFO, which the host drains with read strobes.

Four modes exist. In single mode one requested channel is converted once. In repeat mode that channel is converted again and again. In sweep mode one pass is made through a fixed channel order. In looped sweep mode the pass is repeated, but each new pass waits until the host has emptied the FIFO. The trigger field sets both the number of entries in a sweep and the FIFO level at which the interrupt fires. A second parameter variant serves four-channel converters; in that variant order code 00 acts like 01, 01 gives 0,1,2,3,..., 10 gives 0,0,1,1,2,2,3,3 and 11 gives 0,1,0,1,...

A single status pin serves either as a busy/end-of-conversion line or as a latched, active-low interrupt. Writing a new configuration cancels any work in progress and empties the FIFO.

Top module: `chan_sweep_seq`

## Requirements
- R1: After reset, `eoc_int_n` is 1, `conv_start` is 0, `chan_sel` is 0, `fifo_empty` is 1 and `fifo_ovf` is 0.
- R2: With `cfg_mode`=00 (single), a `conv_req` gives exactly one one-cycle `conv_start` with `chan_sel` equal to the `conv_chan` captured with the request. The result is pushed to the FIFO and the block returns to idle.
- R3: With `cfg_mode`=01 (repeat), the captured channel is converted again after every done strobe, with `chan_sel` unchanged, until the next configuration write.
- R4: With `cfg_mode`=10 or 11 (sweeps), `conv_chan` is ignored and entry i of the sweep (NUM_CH=8) uses channel i for `cfg_order`=00, (2i mod 8) for 01, 2*floor(i/2) for 10 and 2*(i mod 2) for 11.
- R5: The sweep length is 8, 6, 4 or 2 entries for `cfg_trig` = 00, 01, 10, 11. In mode 10 exactly that many conversions run, and then the block goes idle.
- R6: In mode 11, once a sweep is complete, no new `conv_start` occurs while the FIFO holds data. After the FIFO is read empty, a new sweep starts at entry 0.
- R7: With `cfg_pin_eoc`=0 (interrupt function), `eoc_int_n` falls after a result is stored. In modes 00 and 01 this happens for every result. In modes 10 and 11 it happens when the FIFO level reaches the sweep length. The pin then stays low until a `fifo_rd` strobe.
- R8: With `cfg_pin_eoc`=1 (end-of-conversion function), `eoc_int_n` is 0 from the `conv_start` cycle until the done strobe is taken, and 1 when no conversion is in progress.
- R9: The FIFO returns results in arrival order, with the oldest shown on `fifo_rdata`. It holds 8 results. A result that arrives while it is full (and not being read) is dropped and sets the sticky `fifo_ovf`.
- R10: A `cfg_wr` aborts any conversion sequence, returns the sequencer to idle, empties the FIFO and clears `fifo_ovf` and a pending interrupt.
- R11: A `conv_req` while a conversion sequence is active, or a `conv_done` when no conversion is awaited, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode: 00 single, 01 repeat, 10 sweep, 11 looped sweep |
| cfg_order | input | 2 | Sweep order code |
| cfg_pin_eoc | input | 1 | Pin function: 1 end-of-conversion, 0 interrupt |
| cfg_trig | input | 2 | Trigger level and sweep length code |
| conv_req | input | 1 | Conversion start request |
| conv_chan | input | CH_W | Channel for single and repeat modes |
| conv_done | input | 1 | Converter done strobe |
| conv_result | input | DATA_W | Result that goes with `conv_done` |
| fifo_rd | input | 1 | FIFO read (pop) strobe |
| chan_sel | output | CH_W | Channel presented to the converter |
| conv_start | output | 1 | One-cycle start-conversion pulse |
| eoc_int_n | output | 1 | End-of-conversion or active-low interrupt |
| fifo_rdata | output | DATA_W | Oldest FIFO entry |
| fifo_empty | output | 1 | FIFO holds no result |
| fifo_ovf | output | 1 | Sticky FIFO overflow flag |

## Verification
The bench targets the looped sweep hold-off. A design that restarted too early would issue a start pulse while one result is still unread, or it would resume mid-sequence rather than at entry 0. It fills the FIFO with one sweep and runs a second sweep into it. A FIFO that overwrote instead of dropping would return second-sweep data, and a missing sticky flag would leave `fifo_ovf` low. It aborts repeat mode while a conversion is outstanding, so a late done strobe that leaked into the FIFO after the configuration write shows up as a non-empty FIFO. Random sweeps over every order code and trigger value expose wrong channel patterns or off-by-one sweep lengths as extra or wrong start pulses.

// File: rtl/seq_pkg.sv
package seq_pkg;

   typedef enum logic [1:0] {
      MODE_ONE    = 2'b00,
      MODE_REPEAT = 2'b01,
      MODE_SWEEP  = 2'b10,
      MODE_LOOP   = 2'b11
   } conv_mode_e;

   typedef struct packed {
      conv_mode_e mode;
      logic [1:0] order;
      logic       pin_eoc;
      logic [1:0] trig;
   } seq_cfg_t;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_LAUNCH  = 2'd1,
      ST_CONVERT = 2'd2,
      ST_DRAIN   = 2'd3
   } seq_state_e;

   function automatic logic is_sweep(conv_mode_e m);
      return (m == MODE_SWEEP) || (m == MODE_LOOP);
   endfunction

endpackage

// File: rtl/seq_order.sv
module seq_order #(
   parameter int NUM_CH = 8,
   parameter int IDX_W  = 3,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic [1:0]       order,
   input  logic [IDX_W-1:0] idx,
   output logic [CH_W-1:0]  chan
);

   generate
      if (IDX_W != 3) begin : g_bad_idx
         $error("seq_order: sweep index must be 3 bits");
      end
      if (NUM_CH == 8) begin : g_oct
         always_comb begin
            unique case (order)
               2'b00:   chan = idx;
               2'b01:   chan = {idx[1:0], 1'b0};
               2'b10:   chan = {idx[2:1], 1'b0};
               default: chan = {1'b0, idx[0], 1'b0};
            endcase
         end
      end else if (NUM_CH == 4) begin : g_quad
         always_comb begin
            unique case (order)
               2'b10:   chan = idx[2:1];
               2'b11:   chan = {1'b0, idx[0]};
               default: chan = idx[1:0];
            endcase
         end
      end else begin : g_bad_ch
         $error("seq_order: NUM_CH must be 4 or 8");
      end
   endgenerate

endmodule

// File: rtl/seq_fifo.sv
module seq_fifo #(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic              empty,
   output logic              accept,
   output logic [LVL_W-1:0]  level,
   output logic              ovf
);

   generate
      if ((1 << PTR_W) != DEPTH) begin : g_bad_depth
         $error("seq_fifo: DEPTH must be a power of two");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              pop_eff;

   assign empty   = (level == '0);
   assign pop_eff = pop && !empty;
   assign accept  = push && ((level != LVL_W'(DEPTH)) || pop_eff);
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (accept && !flush) begin
         mem[wr_ptr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
         ovf    <= 1'b0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
         ovf    <= 1'b0;
      end else begin
         if (accept) begin
            wr_ptr <= wr_ptr + PTR_W'(1);
         end
         if (pop_eff) begin
            rd_ptr <= rd_ptr + PTR_W'(1);
         end
         if (accept && !pop_eff) begin
            level <= level + LVL_W'(1);
         end else if (!accept && pop_eff) begin
            level <= level - LVL_W'(1);
         end
         if (push && !accept) begin
            ovf <= 1'b1;
         end
      end
   end

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   assert_drop_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && level == LVL_W'(DEPTH) && !flush) |=> (ovf && level == LVL_W'(DEPTH)));

   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !flush) |=> ovf);

   assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && !ovf));

endmodule

// File: rtl/seq_pin.sv
module seq_pin (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic use_eoc,
   input  logic in_conv,
   input  logic int_set,
   input  logic int_clr,
   output logic pin_n
);

   logic int_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_flag <= 1'b0;
      end else if (flush) begin
         int_flag <= 1'b0;
      end else if (int_set) begin
         int_flag <= 1'b1;
      end else if (int_clr) begin
         int_flag <= 1'b0;
      end
   end

   assign pin_n = use_eoc ? !in_conv : !int_flag;

   assert_int_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!use_eoc && !pin_n && !int_clr && !flush && $stable(use_eoc)) |=> !pin_n);

   assert_int_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (int_set && !flush && !use_eoc && $stable(use_eoc)) |=> !pin_n);

endmodule

// File: rtl/chan_sweep_seq.sv
module chan_sweep_seq
   import seq_pkg::*;
#(
   parameter int NUM_CH     = 8,
   parameter int DATA_W     = 12,
   parameter int FIFO_DEPTH = 8,
   localparam int CH_W      = $clog2(NUM_CH),
   localparam int IDX_W     = $clog2(FIFO_DEPTH),
   localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_mode,
   input  logic [1:0]        cfg_order,
   input  logic              cfg_pin_eoc,
   input  logic [1:0]        cfg_trig,
   input  logic              conv_req,
   input  logic [CH_W-1:0]   conv_chan,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_result,
   input  logic              fifo_rd,
   output logic [CH_W-1:0]   chan_sel,
   output logic              conv_start,
   output logic              eoc_int_n,
   output logic [DATA_W-1:0] fifo_rdata,
   output logic              fifo_empty,
   output logic              fifo_ovf
);

   generate
      if (FIFO_DEPTH != 8) begin : g_bad_fifo
         $error("chan_sweep_seq: trigger encoding needs an 8-entry FIFO");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("chan_sweep_seq: DATA_W must be positive");
      end
   endgenerate

   seq_cfg_t          cfg_q;
   seq_state_e        st;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  look_idx;
   logic [CH_W-1:0]   look_chan;
   logic [LVL_W-1:0]  sweep_len;
   logic [LVL_W-1:0]  lvl;
   logic [LVL_W-1:0]  lvl_after;
   logic              last_entry;
   logic              take_done;
   logic              push_ok;
   logic              pop_eff;
   logic              int_set;
   logic              in_conv;

   // Sweep length doubles as the interrupt level: 8, 6, 4, 2 entries.
   assign sweep_len  = LVL_W'(FIFO_DEPTH) - LVL_W'(cfg_q.trig) * LVL_W'(FIFO_DEPTH / 4);
   assign last_entry = ({1'b0, idx} == sweep_len - LVL_W'(1));
   assign take_done  = (st == ST_CONVERT) && conv_done && !cfg_wr;
   assign look_idx   = (st == ST_CONVERT) ? idx + IDX_W'(1) : '0;
   assign in_conv    = (st == ST_LAUNCH) || (st == ST_CONVERT);
   assign conv_start = (st == ST_LAUNCH);

   seq_order #(
      .NUM_CH (NUM_CH),
      .IDX_W  (IDX_W)
   ) i_order (
      .order (cfg_q.order),
      .idx   (look_idx),
      .chan  (look_chan)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         st       <= ST_IDLE;
         idx      <= '0;
         chan_sel <= '0;
      end else if (cfg_wr) begin
         cfg_q    <= '{mode: conv_mode_e'(cfg_mode), order: cfg_order,
                       pin_eoc: cfg_pin_eoc, trig: cfg_trig};
         st       <= ST_IDLE;
         idx      <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (conv_req) begin
                  idx      <= '0;
                  chan_sel <= is_sweep(cfg_q.mode) ? look_chan : conv_chan;
                  st       <= ST_LAUNCH;
               end
            end
            ST_LAUNCH: begin
               st <= ST_CONVERT;
            end
            ST_CONVERT: begin
               if (conv_done) begin
                  unique case (cfg_q.mode)
                     MODE_ONE:    st <= ST_IDLE;
                     MODE_REPEAT: st <= ST_LAUNCH;
                     default: begin
                        if (last_entry) begin
                           st <= (cfg_q.mode == MODE_LOOP) ? ST_DRAIN : ST_IDLE;
                        end else begin
                           idx      <= idx + IDX_W'(1);
                           chan_sel <= look_chan;
                           st       <= ST_LAUNCH;
                        end
                     end
                  endcase
               end
            end
            default: begin
               if (fifo_empty) begin
                  idx      <= '0;
                  chan_sel <= look_chan;
                  st       <= ST_LAUNCH;
               end
            end
         endcase
      end
   end

   seq_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (FIFO_DEPTH)
   ) i_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (cfg_wr),
      .push   (take_done),
      .wdata  (conv_result),
      .pop    (fifo_rd),
      .rdata  (fifo_rdata),
      .empty  (fifo_empty),
      .accept (push_ok),
      .level  (lvl),
      .ovf    (fifo_ovf)
   );

   assign pop_eff   = fifo_rd && !fifo_empty;
   assign lvl_after = lvl + LVL_W'(1) - LVL_W'(pop_eff);
   assign int_set   = push_ok && (!is_sweep(cfg_q.mode) || (lvl_after == sweep_len));

   seq_pin i_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (cfg_wr),
      .use_eoc (cfg_q.pin_eoc),
      .in_conv (in_conv),
      .int_set (int_set),
      .int_clr (fifo_rd),
      .pin_n   (eoc_int_n)
   );

   assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   assert_single_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (take_done && cfg_q.mode == MODE_ONE) |=> (st == ST_IDLE));

   assert_repeat_chan_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && cfg_q.mode == MODE_REPEAT && !cfg_wr) |=> $stable(chan_sel));

   assert_drain_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DRAIN && !fifo_empty && !cfg_wr) |=> !conv_start);

   assert_eoc_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.pin_eoc && conv_start) |-> !eoc_int_n);

   assert_cfg_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (st == ST_IDLE && fifo_empty && !fifo_ovf));

   assert_busy_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CONVERT && !conv_done && !cfg_wr) |=> (st == ST_CONVERT));

endmodule

// File: tb/test_chan_sweep_seq.sv
`timescale 1ns/1ps
module test_chan_sweep_seq;

   localparam int CH_W = 3;
   localparam int DW   = 12;
   localparam int LOGN = 1024;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [1:0]    cfg_mode = '0;
   logic [1:0]    cfg_order = '0;
   logic          cfg_pin_eoc = 1'b0;
   logic [1:0]    cfg_trig = '0;
   logic          conv_req = 1'b0;
   logic [CH_W-1:0] conv_chan = '0;
   logic          done_i = 1'b0;
   logic          spur = 1'b0;
   logic [DW-1:0] done_data = '0;
   logic          fifo_rd = 1'b0;
   logic [CH_W-1:0] chan_sel;
   logic          conv_start;
   logic          eoc_int_n;
   logic [DW-1:0] fifo_rdata;
   logic          fifo_empty;
   logic          fifo_ovf;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   chan_sweep_seq i_chan_sweep_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr      (cfg_wr),
      .cfg_mode    (cfg_mode),
      .cfg_order   (cfg_order),
      .cfg_pin_eoc (cfg_pin_eoc),
      .cfg_trig    (cfg_trig),
      .conv_req    (conv_req),
      .conv_chan   (conv_chan),
      .conv_done   (done_i | spur),
      .conv_result (done_data),
      .fifo_rd     (fifo_rd),
      .chan_sel    (chan_sel),
      .conv_start  (conv_start),
      .eoc_int_n   (eoc_int_n),
      .fifo_rdata  (fifo_rdata),
      .fifo_empty  (fifo_empty),
      .fifo_ovf    (fifo_ovf)
   );

   // Converter stub: logs every start and answers after stub_dly cycles.
   int ch_log   [LOGN];
   int data_log [LOGN];
   int n_start = 0;
   int n_done  = 0;
   int pend    = 0;
   int stub_dly = 2;

   function automatic int mkdata(int k, int ch);
      return ((k * 53) + (ch * 7) + 1) & 12'hFFF;
   endfunction

   always @(negedge clk) begin
      done_i = 1'b0;
      if (pend > 0) begin
         pend = pend - 1;
         if (pend == 0) begin
            done_i    = 1'b1;
            done_data = DW'(data_log[n_done % LOGN]);
            n_done    = n_done + 1;
         end
      end
      if (conv_start) begin
         ch_log[n_start % LOGN]   = int'(chan_sel);
         data_log[n_start % LOGN] = mkdata(n_start, int'(chan_sel));
         n_start = n_start + 1;
         pend    = stub_dly;
      end
   end

   function automatic int exp_chan(int ord, int i);
      case (ord)
         0:       return i;
         1:       return (2 * i) % 8;
         2:       return 2 * (i / 2);
         default: return 2 * (i % 2);
      endcase
   endfunction

   function automatic int sweep_len(int trig);
      return 8 - 2 * trig;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic settle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic configure(int mode, int ord, bit eoc, int trig);
      @(negedge clk);
      cfg_wr      = 1'b1;
      cfg_mode    = 2'(mode);
      cfg_order   = 2'(ord);
      cfg_pin_eoc = eoc;
      cfg_trig    = 2'(trig);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic request(int ch);
      conv_req  = 1'b1;
      conv_chan = CH_W'(ch);
      @(negedge clk);
      conv_req  = 1'b0;
   endtask

   task automatic pop(output int val);
      val     = int'(fifo_rdata);
      fifo_rd = 1'b1;
      @(negedge clk);
      fifo_rd = 1'b0;
   endtask

   task automatic wait_starts(int n);
      int t = 0;
      while (n_start < n && t < 3000) begin
         @(negedge clk);
         t++;
      end
   endtask

   task automatic wait_quiet();
      int t = 0;
      while ((n_done < n_start || pend != 0) && t < 3000) begin
         @(negedge clk);
         t++;
      end
      settle(3);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int base;
      int v;
      void'($urandom(32'd2718));
      settle(4);
      rst_n = 1'b1;
      settle(2);

      // R1 reset state
      check(eoc_int_n == 1'b1, "R1", "pin after reset", int'(eoc_int_n), 1);
      check(conv_start == 1'b0, "R1", "start after reset", int'(conv_start), 0);
      check(chan_sel == '0, "R1", "chan_sel after reset", int'(chan_sel), 0);
      check(fifo_empty && !fifo_ovf, "R1", "fifo flags after reset",
            int'({fifo_empty, fifo_ovf}), 2);

      // R11: stray done while idle is ignored
      spur = 1'b1;
      @(negedge clk);
      spur = 1'b0;
      settle(2);
      check(fifo_empty == 1'b1, "R11", "stray done stored", int'(fifo_empty), 1);

      // R2 / R7: single conversions, interrupt pin function, random channels
      configure(0, 0, 1'b0, 0);
      for (int it = 0; it < 5; it++) begin
         int ch = int'($urandom_range(7, 0));
         stub_dly = int'($urandom_range(6, 1));
         base = n_start;
         request(ch);
         wait_quiet();
         settle(6);
         check(n_start == base + 1, "R2", "single start count", n_start - base, 1);
         check(ch_log[base % LOGN] == ch, "R2", "single channel", ch_log[base % LOGN], ch);
         check(eoc_int_n == 1'b0, "R7", "int after single result", int'(eoc_int_n), 0);
         pop(v);
         check(v == data_log[base % LOGN], "R9", "single result data", v, data_log[base % LOGN]);
         check(eoc_int_n == 1'b1 && fifo_empty, "R7", "int cleared by read",
               int'(eoc_int_n), 1);
      end

      // R8: end-of-conversion pin function
      configure(0, 0, 1'b1, 0);
      stub_dly = 5;
      check(eoc_int_n == 1'b1, "R8", "eoc idle level", int'(eoc_int_n), 1);
      request(6);
      check(eoc_int_n == 1'b0, "R8", "eoc low at start", int'(eoc_int_n), 0);
      settle(2);
      check(eoc_int_n == 1'b0, "R8", "eoc low while converting", int'(eoc_int_n), 0);
      wait_quiet();
      check(eoc_int_n == 1'b1, "R8", "eoc high after done", int'(eoc_int_n), 1);
      pop(v);

      // R3 / R10: repeat mode, then abort with a conversion outstanding
      configure(1, 0, 1'b0, 0);
      stub_dly = 3;
      base = n_start;
      request(5);
      wait_starts(base + 4);
      for (int k = 0; k < 4; k++) begin
         check(ch_log[(base + k) % LOGN] == 5, "R3", "repeat channel",
               ch_log[(base + k) % LOGN], 5);
      end
      check(fifo_empty == 1'b0, "R3", "repeat stored results", int'(fifo_empty), 0);
      configure(1, 0, 1'b0, 0);
      check(fifo_empty == 1'b1 && fifo_ovf == 1'b0, "R10", "flush on config",
            int'(fifo_empty), 1);
      wait_quiet();
      base = n_start;
      settle(20);
      check(n_start == base, "R10", "no start after abort", n_start - base, 0);
      check(fifo_empty == 1'b1, "R11", "late done after abort ignored", int'(fifo_empty), 1);

      // R4 / R5 / R11: random sweeps covering every order code
      for (int it = 0; it < 8; it++) begin
         int ord = it % 4;
         int trig = int'($urandom_range(3, 0));
         int len = sweep_len(trig);
         stub_dly = int'($urandom_range(5, 1));
         configure(2, ord, 1'b0, trig);
         base = n_start;
         request(int'($urandom_range(7, 0)));
         check(eoc_int_n == 1'b1, "R7", "no int at sweep start", int'(eoc_int_n), 1);
         settle(1);
         request(7);
         wait_starts(base + len);
         wait_quiet();
         settle(10);
         check(n_start == base + len, "R5", "sweep length", n_start - base, len);
         for (int k = 0; k < len; k++) begin
            check(ch_log[(base + k) % LOGN] == exp_chan(ord, k), "R4", "sweep channel",
                  ch_log[(base + k) % LOGN], exp_chan(ord, k));
         end
         check(eoc_int_n == 1'b0, "R7", "int at sweep level", int'(eoc_int_n), 0);
         for (int k = 0; k < len; k++) begin
            pop(v);
            check(v == data_log[(base + k) % LOGN], "R9", "sweep data order", v,
                  data_log[(base + k) % LOGN]);
         end
         check(fifo_empty == 1'b1, "R9", "empty after sweep reads", int'(fifo_empty), 1);
      end

      // R6: looped sweep waits for an empty FIFO
      configure(3, 1, 1'b0, 3);
      stub_dly = 2;
      base = n_start;
      request(0);
      wait_starts(base + 2);
      wait_quiet();
      settle(25);
      check(n_start == base + 2, "R6", "hold while fifo full", n_start - base, 2);
      pop(v);
      settle(20);
      check(n_start == base + 2, "R6", "hold with one entry left", n_start - base, 2);
      pop(v);
      wait_starts(base + 3);
      check(n_start == base + 3, "R6", "restart after empty", n_start - base, 3);
      check(ch_log[(base + 2) % LOGN] == exp_chan(1, 0), "R6", "restart at entry 0",
            ch_log[(base + 2) % LOGN], exp_chan(1, 0));
      configure(0, 0, 1'b0, 0);
      wait_quiet();

      // R9 / R10: overflow by a second full sweep
      configure(2, 0, 1'b0, 0);
      stub_dly = 1;
      base = n_start;
      request(0);
      wait_starts(base + 8);
      wait_quiet();
      check(fifo_ovf == 1'b0, "R9", "no overflow at exactly full", int'(fifo_ovf), 0);
      request(0);
      wait_starts(base + 16);
      wait_quiet();
      check(fifo_ovf == 1'b1, "R9", "overflow flag set", int'(fifo_ovf), 1);
      for (int k = 0; k < 8; k++) begin
         pop(v);
         check(v == data_log[(base + k) % LOGN], "R9", "kept oldest data", v,
               data_log[(base + k) % LOGN]);
      end
      check(fifo_empty == 1'b1 && fifo_ovf == 1'b1, "R9", "empty after 8 reads, flag sticky",
            int'({fifo_empty, fifo_ovf}), 3);
      configure(0, 0, 1'b0, 0);
      check(fifo_ovf == 1'b0, "R10", "config clears overflow", int'(fifo_ovf), 0);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule